// File: doc/BRIEF.md
# Seven-Segment Space Vector PWM Sequencer

This block drives the three upper-switch gate states of a two-level three-phase inverter, one switching period at a time. A controller supplies a signed reference pair (alpha, beta), or names a sector directly. It also supplies two active dwell counts and the period length, all in clock ticks. The block works out which 60-degree sector holds the reference. It then plays a symmetric seven-segment pattern made of the two adjacent active vectors and both zero vectors, and pulses a strobe on the first tick of every period.

The sector is found by comparing magnitudes, with no arctangent. The beta sign picks the half plane, and |beta| scaled by 2^FRAC is compared with |alpha| times a fixed-point square root of three. The inputs are sampled only when a period begins, so a controller may update them at any time. If the active counts together exceed the period, they are reduced in proportion so that the zero time never goes negative. Dwell-time trigonometry, dead time and overmodulation stay with the controller.

Top module: `svpwm_seq`

## Requirements
- R1: When `useSector` is 0, the sector (1..6, sector 1 starting at 0 degrees, counter-clockwise) comes from `alpha`/`beta`. The positive alpha axis belongs to sector 1 and the negative alpha axis to sector 4. The positive beta axis and an exact 60-degree ray belong to sector 2, and the negative beta axis to sector 5. Sector 2 is chosen when |beta|*2^FRAC >= |alpha|*SQRT3_Q in the upper half with alpha > 0. The origin maps to sector 1.
- R2: When `useSector` is 1, `sectorIn` is used directly. The values 0 and 7 are treated as sector 1.
- R3: Gate code {sa,sb,sc}: V1=100, V2=110, V3=010, V4=011, V5=001, V6=101, V0=000, V7=111. Sector n uses Vn and Vn+1 (V6 wraps to V1). Odd sectors play Vn before Vn+1 on the way to the centre; even sectors play Vn+1 first.
- R4: With h1=floor(T1/2), h2=floor(T2/2), Z=Ts-2*h1-2*h2 and q=floor(Z/4), the segments are V0 for q ticks, first active for h1, second active for h2, V7 for Z-2q, second active for h2, first active for h1 and V0 for q. Odd remainders of T1, T2 and the zero time all go to the centre V7 segment. Empty segments are skipped.
- R5: If T1+T2 > Ts, the block uses T1' = floor(T1*Ts/(T1+T2)) and T2' = Ts-T1' in place of T1 and T2.
- R6: A period lasts Ts ticks, with a minimum of 2 (a smaller Ts gives 2). `periodStart` is high on the first tick of each period only.
- R7: Sector, T1, T2 and Ts are sampled only at the clock edge that starts a period. Changes at other times do not affect the running period and take effect in the next one.
- R8: When all seven segments are non-empty, every change of the gate code within a period flips exactly one bit, and the period begins and ends on V0.
- R9: During reset the gate outputs are 000 and `periodStart` is 0. The first period begins on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alpha | input | REF_W | Signed alpha component of the reference |
| beta | input | REF_W | Signed beta component of the reference |
| useSector | input | 1 | 1 selects `sectorIn` instead of the computed sector |
| sectorIn | input | 3 | Directly supplied sector number |
| t1 | input | CNT_W | Dwell of the first-numbered active vector, in ticks |
| t2 | input | CNT_W | Dwell of the second-numbered active vector, in ticks |
| ts | input | CNT_W | Switching period in ticks |
| sa | output | 1 | Upper-switch state, phase A |
| sb | output | 1 | Upper-switch state, phase B |
| sc | output | 1 | Upper-switch state, phase C |
| periodStart | output | 1 | High on the first tick of each period |

## Verification
Inputs placed before a start edge show up in the cycle just after that edge. In that cycle `periodStart` is high and tick 0 of the new pattern is on the gate pins. Tick k of the period is visible k cycles later, because the gates decode the tick counter and the sampled values without a further register. The bench drives inputs on a falling edge and waits for a falling edge where `periodStart` is high. It then compares every tick of that period in turn and expects the next strobe exactly Ts ticks (or 2) later. For the sampling test it changes the inputs on tick 3 and expects the running period to stay unchanged and the following period to follow the new inputs.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  typedef logic [2:0] swState_t;   // {Sa, Sb, Sc}

  localparam swState_t ZERO_LO = 3'b000;
  localparam swState_t ZERO_HI = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // sample new inputs, tick counter restarts
    logic advance;  // tick counter steps
  } ctrlStrb_t;

  // active vector code for sector number n (1..6)
  function automatic swState_t activeVec(input logic [2:0] n);
    case (n)
      3'd1:    activeVec = 3'b100;
      3'd2:    activeVec = 3'b110;
      3'd3:    activeVec = 3'b010;
      3'd4:    activeVec = 3'b011;
      3'd5:    activeVec = 3'b001;
      default: activeVec = 3'b101;
    endcase
  endfunction

endpackage

// File: rtl/svpwm_sector.sv
module svpwm_sector #(
  parameter int REF_W   = 16,
  parameter int FRAC    = 14,
  parameter int SQRT3_Q = 28378
) (
  input  logic [REF_W-1:0] alpha,
  input  logic [REF_W-1:0] beta,
  output logic [2:0]       sector
);
  localparam int CW = REF_W + FRAC + 3;

  logic [REF_W:0] extA, extB, absA, absB;
  logic [CW-1:0]  lhs, rhs;
  logic aNeg, aPos, upper, bLess, bLeq, isOrigin;

  always_comb begin
    extA = {alpha[REF_W-1], alpha};
    extB = {beta[REF_W-1], beta};
    absA = extA[REF_W] ? (~extA + 1'b1) : extA;
    absB = extB[REF_W] ? (~extB + 1'b1) : extB;
    lhs  = CW'(absB) << FRAC;
    rhs  = CW'(absA) * CW'(SQRT3_Q);
    bLess = lhs < rhs;
    bLeq  = lhs <= rhs;
    aNeg  = alpha[REF_W-1];
    aPos  = !aNeg && (alpha != '0);
    isOrigin = (alpha == '0) && (beta == '0);
    upper = !beta[REF_W-1] && !((beta == '0) && aNeg);
    if (isOrigin)     sector = 3'd1;
    else if (upper) begin
      if (aPos)       sector = bLess ? 3'd1 : 3'd2;
      else            sector = bLeq  ? 3'd3 : 3'd2;
    end else begin
      if (aNeg)       sector = bLess ? 3'd4 : 3'd5;
      else            sector = bLeq  ? 3'd6 : 3'd5;
    end
  end
endmodule

// File: rtl/svpwm_ctrl.sv
module svpwm_ctrl
  import svpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodLen,
  output logic [CNT_W-1:0] cnt,
  output ctrlStrb_t        strb,
  output logic             periodStart
);
  logic started;
  logic lastTick;

  always_comb begin
    lastTick     = (cnt == periodLen - 1'b1);
    strb.load    = !started || lastTick;
    strb.advance = started && !lastTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt         <= '0;
      started     <= 1'b0;
      periodStart <= 1'b0;
    end else begin
      periodStart <= strb.load;
      started     <= 1'b1;
      if (strb.load)         cnt <= '0;
      else if (strb.advance) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/svpwm_datapath.sv
module svpwm_datapath
  import svpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int REF_W   = 16,
  parameter int FRAC    = 14,
  parameter int SQRT3_Q = 28378
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [CNT_W-1:0] cnt,
  input  logic [REF_W-1:0] alpha,
  input  logic [REF_W-1:0] beta,
  input  logic             useSector,
  input  logic [2:0]       sectorIn,
  input  logic [CNT_W-1:0] t1,
  input  logic [CNT_W-1:0] t2,
  input  logic [CNT_W-1:0] ts,
  output logic [CNT_W-1:0] periodLen,
  output logic [2:0]       curSector,
  output logic             fullPattern,
  output swState_t         swVec
);
  localparam int NB = 6;          // segment boundaries inside a period
  localparam int PW = 2 * CNT_W;

  logic [2:0]       idSector, secSel;
  logic [CNT_W-1:0] tsEff, t1s, t2s, h1, h2, zTot, qTot, cTot;
  logic [CNT_W:0]   sumT, divT;
  logic             over, nFull;
  logic [CNT_W-1:0] nb  [NB];
  logic [CNT_W-1:0] bnd [NB];

  svpwm_sector #(.REF_W(REF_W), .FRAC(FRAC), .SQRT3_Q(SQRT3_Q)) u_sector (
    .alpha (alpha),
    .beta  (beta),
    .sector(idSector)
  );

  // next-period values, computed from the live inputs
  always_comb begin
    if (useSector) secSel = ((sectorIn == 3'd0) || (sectorIn == 3'd7)) ? 3'd1 : sectorIn;
    else           secSel = idSector;
    tsEff = (ts < CNT_W'(2)) ? CNT_W'(2) : ts;
    sumT  = {1'b0, t1} + {1'b0, t2};
    over  = sumT > {1'b0, tsEff};
    divT  = (sumT == '0) ? (CNT_W+1)'(1) : sumT;
    t1s   = over ? CNT_W'((PW'(t1) * PW'(tsEff)) / PW'(divT)) : t1;
    t2s   = over ? (tsEff - t1s) : t2;
    h1    = t1s >> 1;
    h2    = t2s >> 1;
    zTot  = tsEff - (h1 << 1) - (h2 << 1);
    qTot  = zTot >> 2;
    cTot  = zTot - (qTot << 1);
    nb[0] = qTot;
    nb[1] = nb[0] + h1;
    nb[2] = nb[1] + h2;
    nb[3] = nb[2] + cTot;
    nb[4] = nb[3] + h2;
    nb[5] = nb[4] + h1;
    nFull = (qTot != '0) && (h1 != '0) && (h2 != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodLen   <= CNT_W'(2);
      curSector   <= 3'd1;
      fullPattern <= 1'b0;
    end else if (strb.load) begin
      periodLen   <= tsEff;
      curSector   <= secSel;
      fullPattern <= nFull;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (!rstN)          bnd[g] <= '0;
      else if (strb.load) bnd[g] <= nb[g];
    end
  end

  // segment index = number of boundaries already passed
  logic [2:0] segIdx, nxtSector;
  swState_t   firstV, secondV;

  always_comb begin
    segIdx = 3'd0;
    for (int i = 0; i < NB; i++) begin
      if (cnt >= bnd[i]) segIdx = segIdx + 3'd1;
    end
    nxtSector = (curSector == 3'd6) ? 3'd1 : curSector + 3'd1;
    if (curSector[0]) begin
      firstV  = activeVec(curSector);
      secondV = activeVec(nxtSector);
    end else begin
      firstV  = activeVec(nxtSector);
      secondV = activeVec(curSector);
    end
    case (segIdx)
      3'd0, 3'd6: swVec = ZERO_LO;
      3'd1, 3'd5: swVec = firstV;
      3'd2, 3'd4: swVec = secondV;
      default:    swVec = ZERO_HI;
    endcase
  end
endmodule

// File: rtl/svpwm_seq.sv
module svpwm_seq
  import svpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int REF_W   = 16,
  parameter int FRAC    = 14,
  parameter int SQRT3_Q = 28378
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REF_W-1:0] alpha,
  input  logic [REF_W-1:0] beta,
  input  logic             useSector,
  input  logic [2:0]       sectorIn,
  input  logic [CNT_W-1:0] t1,
  input  logic [CNT_W-1:0] t2,
  input  logic [CNT_W-1:0] ts,
  output logic             sa,
  output logic             sb,
  output logic             sc,
  output logic             periodStart
);
  ctrlStrb_t        strb;
  logic [CNT_W-1:0] cnt, periodLen;
  logic [2:0]       curSector;
  logic             fullPattern;
  swState_t         swVec;

  svpwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .periodLen  (periodLen),
    .cnt        (cnt),
    .strb       (strb),
    .periodStart(periodStart)
  );

  svpwm_datapath #(.CNT_W(CNT_W), .REF_W(REF_W), .FRAC(FRAC), .SQRT3_Q(SQRT3_Q)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cnt        (cnt),
    .alpha      (alpha),
    .beta       (beta),
    .useSector  (useSector),
    .sectorIn   (sectorIn),
    .t1         (t1),
    .t2         (t2),
    .ts         (ts),
    .periodLen  (periodLen),
    .curSector  (curSector),
    .fullPattern(fullPattern),
    .swVec      (swVec)
  );

  assign sa = swVec[2];
  assign sb = swVec[1];
  assign sc = swVec[0];
endmodule

// File: rtl/svpwm_seq_chk.sv
module svpwm_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             periodStart,
  input logic [2:0]       swVec,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] periodLen,
  input logic [2:0]       curSector,
  input logic             fullPattern
);
  // R6
  period_start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  // R6
  tick_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < periodLen);

  // R7
  sector_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |-> $stable(curSector));

  // R2
  sector_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curSector >= 3'd1) && (curSector <= 3'd6));

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullPattern && !periodStart) |-> ($countones(swVec ^ $past(swVec)) <= 1));

  // R8
  zero_edges_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodStart && fullPattern) |-> (swVec == 3'b000));
endmodule

bind svpwm_seq svpwm_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .periodStart(periodStart),
  .swVec      (swVec),
  .cnt        (cnt),
  .periodLen  (periodLen),
  .curSector  (curSector),
  .fullPattern(fullPattern)
);

// File: tb/svpwm_seq_tb.sv
module svpwm_seq_tb;
  localparam int CNT_W = 16;
  localparam int REF_W = 16;

  typedef struct packed {
    logic [15:0]             tag;
    logic                    useSec;
    logic [2:0]              secIn;
    logic signed [REF_W-1:0] alpha;
    logic signed [REF_W-1:0] beta;
    logic [CNT_W-1:0]        t1;
    logic [CNT_W-1:0]        t2;
    logic [CNT_W-1:0]        ts;
    logic [2:0]              expSec;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{"R1", 1'b0, 3'd0,  16'sd1000,  16'sd100,  16'd20, 16'd20, 16'd80, 3'd1},
    '{"R1", 1'b0, 3'd0,  16'sd100,   16'sd1000, 16'd20, 16'd20, 16'd80, 3'd2},
    '{"R1", 1'b0, 3'd0, -16'sd1000,  16'sd100,  16'd20, 16'd20, 16'd80, 3'd3},
    '{"R1", 1'b0, 3'd0, -16'sd1000, -16'sd100,  16'd20, 16'd20, 16'd80, 3'd4},
    '{"R1", 1'b0, 3'd0,  16'sd100,  -16'sd1000, 16'd20, 16'd20, 16'd80, 3'd5},
    '{"R1", 1'b0, 3'd0,  16'sd1000, -16'sd100,  16'd20, 16'd20, 16'd80, 3'd6},
    '{"R1", 1'b0, 3'd0,  16'sd1000,  16'sd0,    16'd20, 16'd20, 16'd80, 3'd1},
    '{"R1", 1'b0, 3'd0, -16'sd1000,  16'sd0,    16'd20, 16'd20, 16'd80, 3'd4},
    '{"R1", 1'b0, 3'd0,  16'sd0,     16'sd1000, 16'd20, 16'd20, 16'd80, 3'd2},
    '{"R1", 1'b0, 3'd0,  16'sd0,    -16'sd1000, 16'd20, 16'd20, 16'd80, 3'd5},
    '{"R1", 1'b0, 3'd0,  16'sd1000,  16'sd1800, 16'd20, 16'd20, 16'd80, 3'd2},
    '{"R1", 1'b0, 3'd0,  16'sd1000,  16'sd1700, 16'd20, 16'd20, 16'd80, 3'd1},
    '{"R2", 1'b1, 3'd4,  16'sd1000,  16'sd0,    16'd20, 16'd20, 16'd80, 3'd4},
    '{"R2", 1'b1, 3'd7, -16'sd1000,  16'sd0,    16'd20, 16'd20, 16'd80, 3'd1},
    '{"R2", 1'b1, 3'd0, -16'sd1000,  16'sd0,    16'd20, 16'd20, 16'd80, 3'd1},
    '{"R5", 1'b1, 3'd3,  16'sd0,     16'sd0,    16'd300, 16'd300, 16'd200, 3'd3},
    '{"R4", 1'b1, 3'd2,  16'sd0,     16'sd0,    16'd11, 16'd7,  16'd41, 3'd2},
    '{"R6", 1'b1, 3'd6,  16'sd0,     16'sd0,    16'd0,  16'd0,  16'd0,  3'd6},
    '{"R3", 1'b1, 3'd5,  16'sd0,     16'sd0,    16'd40, 16'd0,  16'd40, 3'd5},
    '{"R4", 1'b1, 3'd4,  16'sd0,     16'sd0,    16'd30, 16'd10, 16'd60, 3'd4}
  };

  localparam vec_t LATCH_A = '{"R7", 1'b1, 3'd1, 16'sd0, 16'sd0, 16'd20, 16'd20, 16'd80, 3'd1};
  localparam vec_t LATCH_B = '{"R7", 1'b1, 3'd4, 16'sd0, 16'sd0, 16'd10, 16'd30, 16'd70, 3'd4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [REF_W-1:0] alpha = '0, beta = '0;
  logic useSector = 1'b0;
  logic [2:0] sectorIn = 3'd0;
  logic [CNT_W-1:0] t1 = '0, t2 = '0, ts = '0;
  logic sa, sb, sc, periodStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  svpwm_seq u_dut (
    .clk(clk), .rstN(rstN), .alpha(alpha), .beta(beta),
    .useSector(useSector), .sectorIn(sectorIn),
    .t1(t1), .t2(t2), .ts(ts),
    .sa(sa), .sb(sb), .sc(sc), .periodStart(periodStart)
  );

  function automatic logic [2:0] actCode(int n);
    case (n)
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b010;
      4: return 3'b011;
      5: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  function automatic int effLen(int tsv);
    return (tsv < 2) ? 2 : tsv;
  endfunction

  // segment lengths from R4/R5
  function automatic void segLens(int t1v, int t2v, int tsv, output int lens [7]);
    int tsE, a1, a2, h1, h2, z, q;
    tsE = effLen(tsv);
    a1 = t1v; a2 = t2v;
    if (t1v + t2v > tsE) begin
      a1 = (t1v * tsE) / (t1v + t2v);
      a2 = tsE - a1;
    end
    h1 = a1 / 2; h2 = a2 / 2;
    z = tsE - 2 * h1 - 2 * h2;
    q = z / 4;
    lens = '{q, h1, h2, z - 2 * q, h2, h1, q};
  endfunction

  function automatic logic [2:0] expVec(int sec, int t1v, int t2v, int tsv, int k);
    int lens [7];
    int acc, seg, nxt;
    logic [2:0] f, s;
    segLens(t1v, t2v, tsv, lens);
    acc = 0; seg = 6;
    for (int i = 0; i < 7; i++) begin
      if (seg == 6 && k < acc + lens[i]) seg = i;
      acc += lens[i];
    end
    nxt = (sec == 6) ? 1 : sec + 1;
    if (sec % 2 == 1) begin f = actCode(sec); s = actCode(nxt); end
    else              begin f = actCode(nxt); s = actCode(sec); end
    case (seg)
      0, 6: return 3'b000;
      1, 5: return f;
      2, 4: return s;
      default: return 3'b111;
    endcase
  endfunction

  task automatic applyIn(vec_t v);
    useSector = v.useSec;
    sectorIn  = v.secIn;
    alpha     = v.alpha;
    beta      = v.beta;
    t1        = v.t1;
    t2        = v.t2;
    ts        = v.ts;
  endtask

  task automatic waitStart();
    do @(negedge clk); while (periodStart !== 1'b1);
  endtask

  // called on tick 0 of a period; returns on tick 0 of the next one
  task automatic checkPeriod(vec_t v, bit midSwap, vec_t swapTo);
    int len, bad, badTick, multi, lens [7];
    bit psBad, full;
    logic [2:0] got, exp, badGot, badExp, prev;
    len = effLen(int'(v.ts));
    segLens(int'(v.t1), int'(v.t2), int'(v.ts), lens);
    full = (lens[0] > 0) && (lens[1] > 0) && (lens[2] > 0);
    bad = 0; badTick = 0; multi = 0; psBad = 1'b0;
    badGot = '0; badExp = '0; prev = '0;
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      if (midSwap && k == 3) applyIn(swapTo);
      got = {sa, sb, sc};
      exp = expVec(int'(v.expSec), int'(v.t1), int'(v.t2), int'(v.ts), k);
      if (got !== exp) begin
        if (bad == 0) begin badTick = k; badGot = got; badExp = exp; end
        bad++;
      end
      if (k > 0 && $countones(got ^ prev) > 1) multi++;
      prev = got;
      if (periodStart !== (k == 0)) psBad = 1'b1;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s gates tick %0d got %b exp %b (sector %0d)",
               v.tag, badTick, badGot, badExp, v.expSec);
    end
    if (full) begin
      checks++;   // R8 single-bit steps, zero vector at both ends
      if (multi != 0 || expVec(int'(v.expSec), int'(v.t1), int'(v.t2), int'(v.ts), 0) != 3'b000) begin
        errors++;
        $display("FAIL R8 multi-bit steps got %0d exp 0", multi);
      end
    end
    @(negedge clk);
    checks++;     // R6 period length and strobe placement
    if (periodStart !== 1'b1 || psBad) begin
      errors++;
      $display("FAIL R6 strobe after %0d ticks got %b exp 1 (stray %0d)", len, periodStart, psBad);
    end
  endtask

  initial begin
    applyIn(TBL[0]);
    repeat (3) @(negedge clk);
    checks++;   // R9 reset state
    if ({sa, sb, sc} !== 3'b000 || periodStart !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset outputs got %b/%b exp 000/0", {sa, sb, sc}, periodStart);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;   // R9 first period right after release
    if (periodStart !== 1'b1) begin
      errors++;
      $display("FAIL R9 first strobe got %b exp 1", periodStart);
    end

    for (int i = 0; i < NV; i++) begin
      applyIn(TBL[i]);
      waitStart();
      checkPeriod(TBL[i], 1'b0, TBL[i]);
    end

    // R7: inputs changed mid-period only affect the next period
    applyIn(LATCH_A);
    waitStart();
    checkPeriod(LATCH_A, 1'b1, LATCH_B);
    checkPeriod(LATCH_B, 1'b0, LATCH_B);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule